// File: doc/BRIEF.md
# Truncating Floating-Point Add/Subtract Unit

This block adds or subtracts two binary floating-point words of parameterized width, 32 bits (8 exponent bits and 23 fraction bits) by default. A caller places both operands and an operation bit on the inputs and pulses `start`. The unit unpacks each word and restores the hidden leading one. It aligns the significand with the smaller exponent by shifting it right. It then forms one signed sum and normalizes that sum one bit position per clock. A single-cycle `done` pulse marks the packed result.

The arithmetic is deliberately simple. Bits shifted out are dropped, so there is no rounding. Gradual underflow, infinities and NaNs are not modelled. Two shortcuts skip the arithmetic altogether: an operand that is zero, and an exponent gap too wide to matter. In both cases the unit returns one of the input words untouched. Subtraction is an addition with the second operand's sign bit inverted.

Top module: `fpadd_trunc`

## Requirements
- R1: The word layout is as follows. The top bit is the sign. The next EXP_W bits hold the exponent, biased by 2^(EXP_W-1)-1. The low FRAC_W bits are the fraction, and the hidden one sits just above them. A biased exponent of 0 marks the operand as zero, whatever its fraction bits hold. The all-ones biased exponent is treated as an ordinary exponent.
- R2: When `sub_op`=1, the top bit of `opb` is inverted first (this gives the effective B), and the word is then added exactly as in an addition.
- R3: If A is zero, the result is the effective B word, bit for bit. Otherwise, if the effective B is zero, the result is the A word, bit for bit.
- R4: When neither operand is zero and the biased exponents differ by more than FRAC_W+1, the result is the word with the larger exponent, unchanged. A gap of exactly FRAC_W+1 still goes through the arithmetic.
- R5: On the arithmetic path, the significand with the smaller exponent is shifted right by the exponent gap and the shifted-out bits are discarded. The sum starts with the larger exponent.
- R6: Each significand is negated when its sign bit is set, and the two are added as signed values. The result sign is the sign of that sum, and its magnitude is what gets normalized.
- R7: Normalization moves the magnitude one position per step, adjusting the exponent by one each step, until the leading one sits in the hidden position. A right shift drops its low bit. The result stores the fraction without the hidden one.
- R8: A signed sum that is exactly zero gives the all-zero word.
- R9: If the normalized exponent is above 2^EXP_W-2, the result is the largest finite value with the sum's sign: exponent 2^EXP_W-2 and an all-ones fraction. If the normalized exponent is below 1, the result is the all-zero word.
- R10: `start` is accepted only while the unit is idle, and a pulse while busy is dropped. `done` is high for exactly one cycle per accepted operation. `result` changes only in that cycle and holds its value until the next `done`.
- R11: `done` rises no more than FRAC_W+4 clock cycles after the edge that accepts `start`.
- R12: After reset, `done` is 0 and `result` is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin an operation when idle |
| sub_op | input | 1 | 1 = subtract B from A, 0 = add |
| opa | input | 1+EXP_W+FRAC_W | Operand A |
| opb | input | 1+EXP_W+FRAC_W | Operand B |
| done | output | 1 | One-cycle pulse, result valid |
| result | output | 1+EXP_W+FRAC_W | Packed sum or difference |

## Verification
A 3-bit-exponent, 2-bit-fraction instance is swept over every operand pair and both operations, and each result is compared against an arithmetic model held in the bench. That sweep reaches several corner cases of the arithmetic:
- A design that checked the fraction instead of the exponent for zero would compute sums where a pass-through is due.
- A gap test off by one would pass through operands that differ by exactly FRAC_W+1.
- A missing saturation would wrap the exponent into a tiny value.
- A sign error on cancellation would return a negated result.

The 32-bit instance is tested with two kinds of stimulus:
- Directed cases for total cancellation and for full-width renormalization, where the latency bound applies.
- Random vectors biased toward near-equal exponents.

A restart pulse issued during a busy operation must leave the original result intact and must not produce a second `done`.

// File: rtl/fpadd_pkg.sv
package fpadd_pkg;

    localparam int DEF_EXP_W  = 8;
    localparam int DEF_FRAC_W = 23;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_EVAL,
        ST_NORM
    } fsm_e;

    typedef enum logic [1:0] {
        PATH_SUM,
        PATH_TAKE_A,
        PATH_TAKE_B
    } path_e;

    // Width of the signed exponent tracker: room for exp_max+1 and for
    // a drop of up to FRAC_W positions below 1.
    function automatic int ext_w(input int ew, input int fw);
        int lw;
        lw = $clog2(fw + 2);
        return ((ew > lw) ? ew : lw) + 2;
    endfunction

endpackage

// File: rtl/fpadd_unpack.sv
module fpadd_unpack #(
    parameter int EXP_W  = fpadd_pkg::DEF_EXP_W,
    parameter int FRAC_W = fpadd_pkg::DEF_FRAC_W,
    localparam int W     = 1 + EXP_W + FRAC_W
) (
    input  logic [W-1:0]      word,
    output logic              sign,
    output logic [EXP_W-1:0]  bexp,
    output logic [FRAC_W:0]   sig,
    output logic              is_zero
);
    // Field split; the hidden one is restored above the fraction.
    assign sign    = word[W-1];
    assign bexp    = word[W-2:FRAC_W];
    assign sig     = {1'b1, word[FRAC_W-1:0]};
    assign is_zero = (bexp == '0);
endmodule

// File: rtl/fpadd_align_sum.sv
module fpadd_align_sum
    import fpadd_pkg::*;
#(
    parameter int EXP_W  = DEF_EXP_W,
    parameter int FRAC_W = DEF_FRAC_W,
    localparam int SW    = FRAC_W + 3
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  sign_a,
    input  logic [EXP_W-1:0]      exp_a,
    input  logic [FRAC_W:0]       sig_a,
    input  logic                  zero_a,
    input  logic                  sign_b,
    input  logic [EXP_W-1:0]      exp_b,
    input  logic [FRAC_W:0]       sig_b,
    input  logic                  zero_b,
    output path_e                 path,
    output logic signed [SW-1:0]  sum,
    output logic [EXP_W-1:0]      big_exp
);
    localparam logic [EXP_W-1:0] GAP_MAX = EXP_W'(FRAC_W + 1);

    logic                  a_ge;
    logic [EXP_W-1:0]      gap;
    logic [FRAC_W:0]       al_a, al_b;
    logic signed [SW-1:0]  va, vb, sa, sb;

    always_comb begin
        a_ge    = (exp_a >= exp_b);
        gap     = a_ge ? (exp_a - exp_b) : (exp_b - exp_a);
        big_exp = a_ge ? exp_a : exp_b;

        // Zero operands win over the gap test; A is tested first.
        if (zero_a)              path = PATH_TAKE_B;
        else if (zero_b)         path = PATH_TAKE_A;
        else if (gap > GAP_MAX)  path = a_ge ? PATH_TAKE_A : PATH_TAKE_B;
        else                     path = PATH_SUM;

        // Right shift of the smaller operand; dropped bits are lost.
        al_a = a_ge ? sig_a : (sig_a >> gap);
        al_b = a_ge ? (sig_b >> gap) : sig_b;

        va  = SW'({2'b00, al_a});
        vb  = SW'({2'b00, al_b});
        sa  = sign_a ? -va : va;
        sb  = sign_b ? -vb : vb;
        sum = sa + sb;
    end

    // The two aligned significands never reach the most negative code.
    AST_SUM_FITS: assert property (@(posedge clk) disable iff (rst)
        (path == PATH_SUM) |-> (sum != {1'b1, {(SW-1){1'b0}}}))
        else $error("sum overflowed working width"); // R6
endmodule

// File: rtl/fpadd_normalize.sv
module fpadd_normalize
    import fpadd_pkg::*;
#(
    parameter int EXP_W  = DEF_EXP_W,
    parameter int FRAC_W = DEF_FRAC_W,
    localparam int W     = 1 + EXP_W + FRAC_W,
    localparam int SW    = FRAC_W + 3,
    localparam int MW    = FRAC_W + 2,
    localparam int XW    = ext_w(EXP_W, FRAC_W),
    localparam int LIMIT = FRAC_W + 3,
    localparam int CW    = $clog2(LIMIT + 1)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  load,
    input  logic signed [SW-1:0]  load_sum,
    input  logic [EXP_W-1:0]      load_exp,
    output logic                  fin,
    output logic [W-1:0]          packed_res
);
    localparam logic signed [XW-1:0] EMAX_X = XW'((1 << EXP_W) - 2);
    localparam logic signed [XW-1:0] ONE_X  = XW'(1);

    logic                  active;
    logic                  sgn;
    logic [MW-1:0]         mag;
    logic signed [XW-1:0]  ex;
    logic [CW-1:0]         cnt;
    logic signed [SW-1:0]  abs_sum;

    assign abs_sum = load_sum[SW-1] ? -load_sum : load_sum;
    assign fin     = active && ((mag[FRAC_W] && !mag[FRAC_W+1]) ||
                                (cnt == CW'(LIMIT)));

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            sgn    <= 1'b0;
            mag    <= '0;
            ex     <= '0;
            cnt    <= '0;
        end else if (load) begin
            active <= 1'b1;
            sgn    <= load_sum[SW-1];
            mag    <= abs_sum[MW-1:0];
            ex     <= signed'({{(XW-EXP_W){1'b0}}, load_exp});
            cnt    <= '0;
        end else if (fin) begin
            active <= 1'b0;
        end else if (active) begin
            cnt <= cnt + 1'b1;
            if (mag[FRAC_W+1]) begin
                mag <= mag >> 1;
                ex  <= ex + ONE_X;
            end else begin
                mag <= mag << 1;
                ex  <= ex - ONE_X;
            end
        end
    end

    // Pack with saturation above the range and flush below it.
    always_comb begin
        if (ex > EMAX_X)
            packed_res = {sgn, EMAX_X[EXP_W-1:0], {FRAC_W{1'b1}}};
        else if (ex < ONE_X)
            packed_res = '0;
        else
            packed_res = {sgn, ex[EXP_W-1:0], mag[FRAC_W-1:0]};
    end

    AST_STEP_BOUND: assert property (@(posedge clk) disable iff (rst)
        active |-> (cnt < CW'(LIMIT)))
        else $error("normalizer exceeded its step budget"); // R11

    AST_LOAD_NONZERO: assert property (@(posedge clk) disable iff (rst)
        load |-> (load_sum != '0))
        else $error("zero sum routed into normalizer"); // R8

    AST_NO_RELOAD_BUSY: assert property (@(posedge clk) disable iff (rst)
        (active && !fin) |-> !load)
        else $error("normalizer reloaded while busy"); // R10
endmodule

// File: rtl/fpadd_trunc.sv
module fpadd_trunc
    import fpadd_pkg::*;
#(
    parameter int EXP_W  = DEF_EXP_W,
    parameter int FRAC_W = DEF_FRAC_W,
    localparam int W     = 1 + EXP_W + FRAC_W,
    localparam int SW    = FRAC_W + 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          sub_op,
    input  logic [W-1:0]  opa,
    input  logic [W-1:0]  opb,
    output logic          done,
    output logic [W-1:0]  result
);
    typedef logic [W-1:0] word_t;

    fsm_e                  state;
    word_t                 opa_q, opb_q;
    word_t                 op_w [2];
    logic                  sgn_v  [2];
    logic [EXP_W-1:0]      exp_v  [2];
    logic [FRAC_W:0]       sig_v  [2];
    logic                  zero_v [2];
    path_e                 path;
    logic signed [SW-1:0]  sum;
    logic [EXP_W-1:0]      big_exp;
    logic                  norm_load;
    logic                  norm_fin;
    word_t                 norm_res;

    assign op_w[0] = opa_q;
    assign op_w[1] = opb_q;

    for (genvar i = 0; i < 2; i++) begin : g_unpack
        fpadd_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_unpack (
            .word    (op_w[i]),
            .sign    (sgn_v[i]),
            .bexp    (exp_v[i]),
            .sig     (sig_v[i]),
            .is_zero (zero_v[i])
        );
    end

    fpadd_align_sum #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_align (
        .clk     (clk),
        .rst     (rst),
        .sign_a  (sgn_v[0]),
        .exp_a   (exp_v[0]),
        .sig_a   (sig_v[0]),
        .zero_a  (zero_v[0]),
        .sign_b  (sgn_v[1]),
        .exp_b   (exp_v[1]),
        .sig_b   (sig_v[1]),
        .zero_b  (zero_v[1]),
        .path    (path),
        .sum     (sum),
        .big_exp (big_exp)
    );

    assign norm_load = (state == ST_EVAL) && (path == PATH_SUM) && (sum != '0);

    fpadd_normalize #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_norm (
        .clk        (clk),
        .rst        (rst),
        .load       (norm_load),
        .load_sum   (sum),
        .load_exp   (big_exp),
        .fin        (norm_fin),
        .packed_res (norm_res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            opa_q  <= '0;
            opb_q  <= '0;
            done   <= 1'b0;
            result <= '0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        opa_q <= opa;
                        opb_q <= opb ^ {sub_op, {(W-1){1'b0}}};
                        state <= ST_EVAL;
                    end
                end
                ST_EVAL: begin
                    unique case (path)
                        PATH_TAKE_A: begin
                            result <= opa_q;
                            done   <= 1'b1;
                            state  <= ST_IDLE;
                        end
                        PATH_TAKE_B: begin
                            result <= opb_q;
                            done   <= 1'b1;
                            state  <= ST_IDLE;
                        end
                        default: begin
                            if (sum == '0) begin
                                result <= '0;
                                done   <= 1'b1;
                                state  <= ST_IDLE;
                            end else begin
                                state  <= ST_NORM;
                            end
                        end
                    endcase
                end
                ST_NORM: begin
                    if (norm_fin) begin
                        result <= norm_res;
                        done   <= 1'b1;
                        state  <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done)
        else $error("done held longer than one cycle"); // R10

    AST_OPS_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (state != ST_IDLE) |=> ($stable(opa_q) && $stable(opb_q)))
        else $error("operands reloaded while busy"); // R10

    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst)
        (result != $past(result)) |-> done)
        else $error("result moved without done"); // R10

    AST_EXP_RANGE: assert property (@(posedge clk) disable iff (rst)
        (state == ST_NORM && norm_fin) |=> (result[W-2:FRAC_W] != '1))
        else $error("normalized exponent left finite range"); // R9
endmodule

// File: tb/tb_fpadd_trunc.sv
module tb_fpadd_trunc;
    localparam int BEW = 8,  BFW = 23, BW = 32;
    localparam int SEW = 3,  SFW = 2,  SWD = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic           b_start = 0, b_sub = 0, b_done;
    logic [BW-1:0]  b_a = '0, b_b = '0, b_res;
    logic           s_start = 0, s_sub = 0, s_done;
    logic [SWD-1:0] s_a = '0, s_b = '0, s_res;

    int nvec = 0;
    int nfail = 0;

    fpadd_trunc #(.EXP_W(BEW), .FRAC_W(BFW)) dut (
        .clk(clk), .rst(rst), .start(b_start), .sub_op(b_sub),
        .opa(b_a), .opb(b_b), .done(b_done), .result(b_res));

    fpadd_trunc #(.EXP_W(SEW), .FRAC_W(SFW)) dut_s (
        .clk(clk), .rst(rst), .start(s_start), .sub_op(s_sub),
        .opa(s_a), .opb(s_b), .done(s_done), .result(s_res));

    // Arithmetic reference model from the requirements.
    function automatic longint model(input longint a_in, input longint b_in,
                                     input bit sub, input int ew, input int fw);
        longint fmask = (64'd1 << fw) - 1;
        longint emask = (64'd1 << ew) - 1;
        int     emax  = (1 << ew) - 2;
        int     w     = 1 + ew + fw;
        longint a = a_in;
        longint b = b_in;
        longint ma, mb, sa, sb, s, m;
        int     ea, eb, e;
        bit     sg;
        if (sub) b = b ^ (64'd1 << (w - 1));                 // R2
        ea = int'((a >> fw) & emask);
        eb = int'((b >> fw) & emask);
        if (ea == 0) return b;                               // R3
        if (eb == 0) return a;
        if (ea - eb > fw + 1) return a;                      // R4
        if (eb - ea > fw + 1) return b;
        ma = (64'd1 << fw) | (a & fmask);                    // R1
        mb = (64'd1 << fw) | (b & fmask);
        if (ea >= eb) begin mb = mb >> (ea - eb); e = ea; end  // R5
        else          begin ma = ma >> (eb - ea); e = eb; end
        sa = (((a >> (w - 1)) & 1) != 0) ? -ma : ma;         // R6
        sb = (((b >> (w - 1)) & 1) != 0) ? -mb : mb;
        s  = sa + sb;
        if (s == 0) return 0;                                // R8
        sg = (s < 0);
        m  = sg ? -s : s;
        while (m >= (64'd2 << fw)) begin m = m >> 1; e++; end  // R7
        while (m <  (64'd1 << fw)) begin m = m << 1; e--; end
        if (e > emax)                                        // R9
            return (longint'(sg) << (w - 1)) | (longint'(emax) << fw) | fmask;
        if (e < 1) return 0;
        return (longint'(sg) << (w - 1)) | (longint'(e) << fw) | (m & fmask);
    endfunction

    task automatic check(input string req, input longint act, input longint exp);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic report_end();
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    endtask

    task automatic run_big(input logic [BW-1:0] a, input logic [BW-1:0] b,
                           input bit op, output logic [BW-1:0] r, output int lat);
        @(negedge clk);
        b_a = a; b_b = b; b_sub = op; b_start = 1;
        @(negedge clk);
        b_start = 0;
        lat = 1;
        while (!b_done && lat < 60) begin @(negedge clk); lat++; end
        r = b_res;
    endtask

    task automatic run_small(input logic [SWD-1:0] a, input logic [SWD-1:0] b,
                             input bit op, output logic [SWD-1:0] r, output int lat);
        @(negedge clk);
        s_a = a; s_b = b; s_sub = op; s_start = 1;
        @(negedge clk);
        s_start = 0;
        lat = 1;
        while (!s_done && lat < 60) begin @(negedge clk); lat++; end
        r = s_res;
    endtask

    task automatic big_case(input string req, input logic [BW-1:0] a,
                            input logic [BW-1:0] b, input bit op);
        logic [BW-1:0] r;
        int lat;
        run_big(a, b, op, r, lat);
        check(req, longint'(r), model(longint'(a), longint'(b), op, BEW, BFW));
        check("R11 latency", longint'(lat <= BFW + 4), 1);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report_end();
    end

    initial begin
        logic [BW-1:0]  rb;
        logic [SWD-1:0] rs;
        int lat, dcount;

        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check("R12 done", longint'(b_done), 0);
        check("R12 result", longint'(b_res), 0);

        // Directed cases on the full-width instance.
        big_case("R6 one plus one",   32'h3F80_0000, 32'h3F80_0000, 0);
        big_case("R8 exact cancel",   32'h3F80_0000, 32'h3F80_0000, 1);
        check("R8 zero word", longint'(b_res), 0);
        big_case("R7 long renorm",    32'h3F80_0001, 32'h3F80_0000, 1);
        check("R7 value", longint'(b_res), 64'h3400_0000);
        big_case("R9 saturate",       32'h7F7F_FFFF, 32'h7F7F_FFFF, 0);
        check("R9 max finite", longint'(b_res), 64'h7F7F_FFFF);
        big_case("R9 flush",          32'h0080_0001, 32'h0080_0000, 1);
        check("R9 zero word", longint'(b_res), 0);
        big_case("R4 gap 24 sums",    32'h4B80_0000, 32'h3F80_0000, 0);
        big_case("R4 gap 25 passes",  32'h4C00_0000, 32'h3F80_0000, 0);
        check("R4 passthrough", longint'(b_res), 64'h4C00_0000);
        big_case("R3 zero A sub",     32'h0000_1234, 32'h3F80_0000, 1);
        check("R3 flipped B", longint'(b_res), 64'hBF80_0000);
        big_case("R3 zero B",         32'h4040_0000, 32'h8000_0000, 0);
        big_case("R2 unlike add",     32'h4040_0000, 32'hC000_0000, 0);
        big_case("R5 truncate align", 32'h4000_0000, 32'h3400_0001, 0);

        // R10: a start pulse while busy is dropped.
        @(negedge clk);
        b_a = 32'h3F80_0001; b_b = 32'h3F80_0000; b_sub = 1; b_start = 1;
        @(negedge clk);
        b_a = 32'h4040_0000; b_b = 32'h4040_0000; b_sub = 0;
        @(negedge clk);
        b_start = 0;
        lat = 2;
        while (!b_done && lat < 60) begin @(negedge clk); lat++; end
        check("R10 busy start ignored", longint'(b_res), 64'h3400_0000);
        rb = b_res;
        dcount = 0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (b_done) dcount++;
        end
        check("R10 no extra done", longint'(dcount), 0);
        check("R10 result held", longint'(b_res), longint'(rb));

        // Random vectors, biased toward near-equal exponents.
        for (int k = 0; k < 1500; k++) begin
            logic [BW-1:0] ra, rbv;
            ra  = $urandom;
            rbv = $urandom;
            if (k % 2 == 0)
                rbv[30:23] = ra[30:23] + 8'($urandom_range(0, 4)) - 8'd2;
            run_big(ra, rbv, k[2], rb, lat);
            check("R5 R6 R7 random", longint'(rb),
                  model(longint'(ra), longint'(rbv), k[2], BEW, BFW));
        end

        // Exhaustive sweep of the small instance.
        for (int a = 0; a < 64; a++)
            for (int b = 0; b < 64; b++)
                for (int op = 0; op < 2; op++) begin
                    run_small(SWD'(a), SWD'(b), op[0], rs, lat);
                    check("R1 R3 R4 R9 sweep", longint'(rs),
                          model(longint'(a), longint'(b), op[0], SEW, SFW));
                    if (lat > SFW + 4)
                        check("R11 small latency", longint'(lat), SFW + 4);
                end

        report_end();
    end
endmodule